// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block runs single read and write cycles on an external bus where address and data share the same 32 pins. An internal client presents a request with an address, write data, a direction bit, an access size and a chip-select number. The block then runs a two-phase cycle on the pins. In the first phase it drives the address and pulses the address strobe for one clock so that an external latch can hold the address. In the second phase it either drives the write data or releases the pins and enables the slave's output driver. The cycle lasts until the slave acknowledges it. The block then returns the captured read data with a one-clock completion pulse.

Each chip select has a port width of 8, 16 or 32 bits. Select 0 takes its width from a strap input that is sampled once after reset. The other selects take their widths from static configuration inputs. An access wider than the target port is cut down to the port width, and the transfer-size and byte-enable outputs show the access that actually runs. The three-state pad is kept outside the block: the block supplies output data, an output-enable and an input data path. An optional timer ends a cycle that gets no acknowledge and flags an error.

Top module: `mux_bus_master`

## Requirements
- R1: An accepted request produces an address phase on the next clock. In that phase `bus_ale` is high for exactly one cycle, `bus_ts_n` is low, `bus_ad_oe` is 1 and `bus_ad_out` equals the request address.
- R2: Exactly one `bus_cs_n` bit is low, the one matching `req_cs`, from the address phase through the cycle in which acknowledge is sampled. All bits are high in the following cycle and whenever the block is idle.
- R3: `bus_rw` is 1 for a read and 0 for a write, and it holds steady for the whole bus cycle.
- R4: In the data phase of a write, `bus_ad_oe` is 1 and `bus_ad_out` carries the write data. In the data phase of a read, `bus_ad_oe` is 0 and `bus_oe_n` is 0. When idle, `bus_ad_oe` is 0 and `bus_oe_n` is 1.
- R5: Acknowledge (`bus_ack_n` low) sampled in the data phase ends the cycle. `bus_ad_in` is captured on that edge for reads, and `rsp_done` pulses for one clock on the next cycle. With acknowledge given in data cycle d (counting from 0), `rsp_done` comes d+2 cycles after the `bus_ale` cycle.
- R6: `bus_be_n[k]` is low only for byte lanes that the access uses. Lane 0 is bits 31:24 and corresponds to address offset 0, and lane 3 is bits 7:0. A byte access uses lane `addr[1:0]`. A 16-bit access uses lanes 0-1 when `addr[1]`=0 and lanes 2-3 when `addr[1]`=1. A 32-bit access uses all four lanes. All bits are high when idle.
- R7: Size codes (request, port width and `bus_tsiz`) are: 01 = 8-bit, 10 = 16-bit, 00 or 11 = 32-bit. The effective size is the narrower of the request size and the port width of the target select, and `bus_tsiz` shows it.
- R8: The port width of select 0 is `boot_strap`, sampled on the first clock edge after reset release. Later changes of `boot_strap` have no effect. Selects 1 to 3 use `cs_width[2*(i-1)+:2]`.
- R9: If no acknowledge arrives in 255 data-phase cycles, the cycle ends with `rsp_done` and `rsp_err` high, 256 cycles after `bus_ale`. An acknowledge in the 255th cycle still ends the cycle normally, and `rsp_err` is 0 after any acknowledged cycle.
- R10: `req_ready` is high only while idle. A `req_valid` raised during a cycle is ignored and starts no address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_strap | input | 2 | Reset-time port width of select 0 |
| cs_width | input | 6 | Port widths of selects 1 to 3, two bits each |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Write data |
| req_read | input | 1 | 1 = read, 0 = write |
| req_size | input | 2 | Requested access size |
| req_cs | input | 2 | Target chip-select number |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Cycle ended by timeout, valid with rsp_done |
| rsp_rdata | output | 32 | Captured read data |
| bus_cs_n | output | 4 | Active-low chip selects |
| bus_ts_n | output | 1 | Active-low transfer start |
| bus_ale | output | 1 | Address latch strobe |
| bus_rw | output | 1 | Direction, 1 = read |
| bus_tsiz | output | 2 | Effective transfer size |
| bus_be_n | output | 4 | Active-low byte-lane enables, bit 0 = MSB lane |
| bus_oe_n | output | 1 | Active-low slave output enable |
| bus_ad_out | output | 32 | Address/data value for the pad |
| bus_ad_oe | output | 1 | Pad drive enable |
| bus_ad_in | input | 32 | Data read from the pad |
| bus_ack_n | input | 1 | Active-low transfer acknowledge |

## Verification
The address phase is due on the cycle after the request is accepted. The first data-phase cycle follows it. The completion pulse comes d+2 cycles after the strobe when acknowledge is given in data cycle d, and 256 cycles after it on a timeout. The bench slave counts cycles from each strobe it sees and asserts acknowledge at a chosen data cycle. It samples every output on the falling edge and compares the measured latency with these figures. The attribute checks are tied to the strobe cycle, the lane and drive checks to the first data cycle, and the response and release checks to the cycle of the pulse.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} mbm_state_e;

  localparam logic [1:0] SZ_LONG = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  // 0 = byte, 1 = word, 2 = longword
  function automatic logic [1:0] size_rank(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_rank = 2'd0;
      SZ_WORD: size_rank = 2'd1;
      default: size_rank = 2'd2;
    endcase
  endfunction

  function automatic logic [1:0] narrower(input logic [1:0] a, input logic [1:0] b);
    narrower = (size_rank(a) <= size_rank(b)) ? a : b;
  endfunction
endpackage

// File: rtl/mbm_width_cfg.sv
module mbm_width_cfg #(
  parameter int NUM_CS = 4,
  localparam int CS_W = $clog2(NUM_CS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                boot_strap,
  input  logic [2*(NUM_CS-1)-1:0]   cs_width,
  input  logic [CS_W-1:0]           sel,
  output logic [1:0]                width
);
  logic       strap_taken_q;
  logic [1:0] boot_w_q;
  logic [1:0] tbl [NUM_CS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_taken_q <= 1'b0;
      boot_w_q      <= 2'b00;
    end else if (!strap_taken_q) begin
      strap_taken_q <= 1'b1;
      boot_w_q      <= boot_strap;
    end
  end

  assign tbl[0] = boot_w_q;
  for (genvar i = 1; i < NUM_CS; i++) begin : g_cfg
    assign tbl[i] = cs_width[2*(i-1) +: 2];
  end

  assign width = tbl[sel];
endmodule

// File: rtl/mbm_lane_decode.sv
module mbm_lane_decode
  import mbm_pkg::*;
(
  input  logic [1:0] req_size,
  input  logic [1:0] port_width,
  input  logic [1:0] addr_lo,
  output logic [1:0] eff_size,
  output logic [3:0] be_n
);
  logic [3:0] lanes;

  always_comb begin
    eff_size = narrower(req_size, port_width);
    case (eff_size)
      SZ_BYTE: lanes = 4'b0001 << addr_lo;
      SZ_WORD: lanes = addr_lo[1] ? 4'b1100 : 4'b0011;
      default: lanes = 4'b1111;
    endcase
    be_n = ~lanes;
  end
endmodule

// File: rtl/mbm_ack_timer.sv
module mbm_ack_timer #(
  parameter bit TMO_EN     = 1'b1,
  parameter int TMO_CYCLES = 255,
  localparam int CNT_W = $clog2(TMO_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ack,
  output logic expire
);
  if (TMO_EN) begin : g_tmo
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
      cnt_d = run ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign expire = run && !ack && (cnt_q == CNT_W'(TMO_CYCLES - 1));
  end else begin : g_no_tmo
    assign expire = 1'b0;
  end
endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
  import mbm_pkg::*;
#(
  parameter int NUM_CS     = 4,
  parameter bit TMO_EN     = 1'b1,
  parameter int TMO_CYCLES = 255,
  localparam int CS_W = $clog2(NUM_CS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              boot_strap,
  input  logic [2*(NUM_CS-1)-1:0] cs_width,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [31:0]             req_addr,
  input  logic [31:0]             req_wdata,
  input  logic                    req_read,
  input  logic [1:0]              req_size,
  input  logic [CS_W-1:0]         req_cs,
  output logic                    rsp_done,
  output logic                    rsp_err,
  output logic [31:0]             rsp_rdata,
  output logic [NUM_CS-1:0]       bus_cs_n,
  output logic                    bus_ts_n,
  output logic                    bus_ale,
  output logic                    bus_rw,
  output logic [1:0]              bus_tsiz,
  output logic [3:0]              bus_be_n,
  output logic                    bus_oe_n,
  output logic [31:0]             bus_ad_out,
  output logic                    bus_ad_oe,
  input  logic [31:0]             bus_ad_in,
  input  logic                    bus_ack_n
);
  mbm_state_e st_q, st_d;
  logic [31:0] addr_q, wdata_q, rdata_q;
  logic        read_q, done_q, err_q;
  logic [CS_W-1:0] cs_q;
  logic [1:0]  size_q, port_w, eff_size;
  logic [3:0]  be_n_q, be_n_d;
  logic        accept, ack, expire, end_cyc, in_cyc, in_addr, in_data;
  logic [NUM_CS-1:0] cs_hot;

  mbm_width_cfg #(.NUM_CS(NUM_CS)) u_width (
    .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap),
    .cs_width(cs_width), .sel(req_cs), .width(port_w)
  );

  mbm_lane_decode u_lanes (
    .req_size(req_size), .port_width(port_w), .addr_lo(req_addr[1:0]),
    .eff_size(eff_size), .be_n(be_n_d)
  );

  mbm_ack_timer #(.TMO_EN(TMO_EN), .TMO_CYCLES(TMO_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(in_data), .ack(ack), .expire(expire)
  );

  assign ack     = !bus_ack_n;
  assign in_addr = (st_q == ST_ADDR);
  assign in_data = (st_q == ST_DATA);
  assign in_cyc  = (st_q != ST_IDLE);
  assign accept  = (st_q == ST_IDLE) && req_valid;
  assign end_cyc = in_data && (ack || expire);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (req_valid) st_d = ST_ADDR;
      ST_ADDR: st_d = ST_DATA;
      ST_DATA: if (ack || expire) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      read_q  <= 1'b1;
      cs_q    <= '0;
      size_q  <= SZ_LONG;
      be_n_q  <= '1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= end_cyc;
      if (end_cyc) err_q <= !ack;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        read_q  <= req_read;
        cs_q    <= req_cs;
        size_q  <= eff_size;
        be_n_q  <= be_n_d;
      end
      if (end_cyc && ack && read_q) rdata_q <= bus_ad_in;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_hot[i] = (cs_q == CS_W'(i));
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign rsp_done   = done_q;
  assign rsp_err    = err_q;
  assign rsp_rdata  = rdata_q;
  assign bus_cs_n   = in_cyc ? ~cs_hot : '1;
  assign bus_ale    = in_addr;
  assign bus_ts_n   = !in_addr;
  assign bus_rw     = in_cyc ? read_q : 1'b1;
  assign bus_tsiz   = in_cyc ? size_q : SZ_LONG;
  assign bus_be_n   = in_cyc ? be_n_q : '1;
  assign bus_oe_n   = !(in_data && read_q);
  assign bus_ad_oe  = in_addr || (in_data && !read_q);
  assign bus_ad_out = in_addr ? addr_q : ((in_data && !read_q) ? wdata_q : '0);
endmodule

// File: rtl/mux_bus_master_chk.sv
module mux_bus_master_chk #(
  parameter int NUM_CS = 4,
  localparam int CS_W = $clog2(NUM_CS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_done,
  input logic              rsp_err,
  input logic [NUM_CS-1:0] bus_cs_n,
  input logic              bus_ts_n,
  input logic              bus_ale,
  input logic              bus_rw,
  input logic [3:0]        bus_be_n,
  input logic              bus_oe_n,
  input logic              bus_ad_oe,
  input logic              bus_ack_n
);
  // R1
  ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> !bus_ale);
  // R1
  ale_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (!bus_ts_n && bus_ad_oe));
  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));
  // R2
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&bus_cs_n) && !bus_ale && !bus_ack_n) |=> (&bus_cs_n));
  // R3
  rw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&bus_cs_n) && !bus_ale) |-> $stable(bus_rw));
  // R4
  oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_n |-> (bus_rw && !bus_ad_oe));
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  // R5
  done_after_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(!(&bus_cs_n)));
  // R6
  be_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&bus_cs_n) |-> (&bus_be_n));
  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err && !$past(rsp_err) |-> rsp_done);
  // R10
  start_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> $past(req_ready && req_valid));
  // R10
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&bus_cs_n));
endmodule

bind mux_bus_master mux_bus_master_chk #(.NUM_CS(NUM_CS)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_done(rsp_done), .rsp_err(rsp_err), .bus_cs_n(bus_cs_n),
  .bus_ts_n(bus_ts_n), .bus_ale(bus_ale), .bus_rw(bus_rw),
  .bus_be_n(bus_be_n), .bus_oe_n(bus_oe_n), .bus_ad_oe(bus_ad_oe),
  .bus_ack_n(bus_ack_n)
);

// File: tb/mux_bus_master_tb_top.sv
`timescale 1ns/1ps
module mux_bus_master_tb_top;
  localparam int TMO = 255;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  boot_strap = 2'b10;
  logic [5:0]  cs_width = {2'b10, 2'b00, 2'b01}; // CS3 word, CS2 long, CS1 byte
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_read = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [1:0]  req_cs = 2'd0;
  logic        rsp_done, rsp_err;
  logic [31:0] rsp_rdata;
  logic [3:0]  bus_cs_n;
  logic        bus_ts_n, bus_ale, bus_rw, bus_oe_n, bus_ad_oe;
  logic [1:0]  bus_tsiz;
  logic [3:0]  bus_be_n;
  logic [31:0] bus_ad_out;
  logic [31:0] bus_ad_in = '0;
  logic        bus_ack_n = 1'b1;

  always #4 clk = ~clk;

  mux_bus_master dut_i (
    .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap), .cs_width(cs_width),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_read(req_read), .req_size(req_size),
    .req_cs(req_cs), .rsp_done(rsp_done), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .bus_cs_n(bus_cs_n), .bus_ts_n(bus_ts_n),
    .bus_ale(bus_ale), .bus_rw(bus_rw), .bus_tsiz(bus_tsiz),
    .bus_be_n(bus_be_n), .bus_oe_n(bus_oe_n), .bus_ad_out(bus_ad_out),
    .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in), .bus_ack_n(bus_ack_n)
  );

  typedef struct {
    logic [1:0]  cs;
    logic        read;
    logic [31:0] addr, wdata, rdata;
    logic [1:0]  tsiz;
    logic [3:0]  be_n;
    int          delay;
    logic        err;
  } txn_t;

  txn_t exp_q[$];
  int   n_vec = 0, n_bad = 0;
  bit   finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor and slave model
  initial begin
    txn_t cur;
    bit   active = 0;
    int   dcnt = 0, lat = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (active && !bus_ale) lat++;
        if (bus_ale) begin
          if (active || exp_q.size() == 0) begin
            chk(0, "R10 unexpected address phase", 32'd1, 32'd0);
          end else begin
            cur = exp_q[0]; active = 1; dcnt = 0; lat = 0;
            chk(bus_ts_n == 1'b0, "R1 ts_n", {31'd0, bus_ts_n}, 32'd0);
            chk(bus_ad_oe && bus_ad_out == cur.addr, "R1 address phase", bus_ad_out, cur.addr);
            chk(bus_cs_n == ~(4'b0001 << cur.cs), "R2 chip select", {28'd0, bus_cs_n}, {28'd0, ~(4'b0001 << cur.cs)});
            chk(bus_rw == cur.read, "R3 rw", {31'd0, bus_rw}, {31'd0, cur.read});
            chk(bus_tsiz == cur.tsiz, "R7 R8 tsiz", {30'd0, bus_tsiz}, {30'd0, cur.tsiz});
            chk(bus_be_n == cur.be_n, "R6 byte enables", {28'd0, bus_be_n}, {28'd0, cur.be_n});
          end
          bus_ack_n <= 1'b1;
        end else if (active && !rsp_done) begin
          if (dcnt == 0) begin
            chk(bus_cs_n == ~(4'b0001 << cur.cs), "R2 select held", {28'd0, bus_cs_n}, {28'd0, ~(4'b0001 << cur.cs)});
            if (cur.read)
              chk(!bus_ad_oe && !bus_oe_n, "R4 read data phase", {30'd0, bus_ad_oe, bus_oe_n}, 32'd0);
            else
              chk(bus_ad_oe && bus_oe_n && bus_ad_out == cur.wdata, "R4 write data", bus_ad_out, cur.wdata);
          end
          bus_ack_n <= (dcnt == cur.delay) ? 1'b0 : 1'b1;
          bus_ad_in <= cur.rdata;
          dcnt++;
        end
        if (rsp_done) begin
          if (!active) begin
            chk(0, "R5 spurious done", 32'd1, 32'd0);
          end else begin
            chk(lat == (cur.err ? TMO + 1 : cur.delay + 2), cur.err ? "R9 timeout latency" : "R5 done latency", lat, cur.err ? TMO + 1 : cur.delay + 2);
            chk(rsp_err == cur.err, "R9 error flag", {31'd0, rsp_err}, {31'd0, cur.err});
            if (cur.read && !cur.err)
              chk(rsp_rdata == cur.rdata, "R5 read data", rsp_rdata, cur.rdata);
            chk(&bus_cs_n, "R2 release after ack", {28'd0, bus_cs_n}, 32'hF);
            chk(!bus_ad_oe && bus_oe_n, "R4 idle bus released", {30'd0, bus_ad_oe, bus_oe_n}, 32'd1);
            void'(exp_q.pop_front());
          end
          active = 0;
          bus_ack_n <= 1'b1;
        end
      end
    end
  end

  task automatic run_txn(input logic [1:0] cs, input logic rd, input logic [31:0] addr,
                         input logic [31:0] wdata, input logic [1:0] size,
                         input logic [1:0] tsiz, input logic [3:0] be_n,
                         input int delay, input logic err, input bit poke);
    txn_t t;
    t.cs = cs; t.read = rd; t.addr = addr; t.wdata = wdata;
    t.rdata = addr ^ 32'h5A5A_C3C3; t.tsiz = tsiz; t.be_n = be_n;
    t.delay = delay; t.err = err;
    exp_q.push_back(t);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_cs = cs; req_read = rd; req_addr = addr;
    req_wdata = wdata; req_size = size;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      // R10: request raised during the data phase must be ignored
      @(negedge clk);
      req_valid = 1; req_addr = 32'hFFFF_FFF0; req_read = ~rd; req_cs = 2'd1;
      @(negedge clk);
      req_valid = 0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state: R2 R4 R10
    chk(req_ready && (&bus_cs_n) && !bus_ale && bus_ts_n, "R2 R10 reset idle", {27'd0, req_ready, bus_cs_n}, 32'h1F);
    chk(!bus_ad_oe && bus_oe_n && !rsp_done && (&bus_be_n), "R4 R6 reset bus", {30'd0, bus_ad_oe, bus_oe_n}, 32'd1);
    @(negedge clk);
    boot_strap = 2'b01; // R8: change after capture has no effect

    run_txn(2'd2, 0, 32'h2000_0000, 32'hDEAD_BEEF, 2'b00, 2'b00, 4'b0000, 0, 0, 0);   // R4 R6
    run_txn(2'd2, 1, 32'h2000_0004, 32'h0,         2'b00, 2'b00, 4'b0000, 3, 0, 0);   // R5
    run_txn(2'd1, 0, 32'h1000_0002, 32'h1122_3344, 2'b10, 2'b01, 4'b1011, 1, 0, 0);   // R7 narrowed
    run_txn(2'd1, 1, 32'h1000_0003, 32'h0,         2'b01, 2'b01, 4'b0111, 1, 0, 0);   // R6 lane 3
    run_txn(2'd3, 1, 32'h3000_0001, 32'h0,         2'b01, 2'b01, 4'b1101, 2, 0, 0);   // R7 byte on word port
    run_txn(2'd3, 0, 32'h3000_0002, 32'hCAFE_F00D, 2'b00, 2'b10, 4'b0011, 0, 0, 0);   // R6 upper word
    run_txn(2'd0, 1, 32'h0000_0000, 32'h0,         2'b00, 2'b10, 4'b1100, 2, 0, 0);   // R8 strap word
    run_txn(2'd2, 1, 32'h2000_0010, 32'h0,         2'b11, 2'b11, 4'b0000, 0, 0, 0);   // R7 code 11
    run_txn(2'd2, 0, 32'h2000_0020, 32'h0BAD_F00D, 2'b00, 2'b00, 4'b0000, 5, 0, 1);   // R10 busy poke
    run_txn(2'd2, 1, 32'h2000_0030, 32'h0,         2'b00, 2'b00, 4'b0000, TMO - 1, 0, 0); // R9 last-cycle ack
    run_txn(2'd2, 1, 32'h2000_0040, 32'h0,         2'b00, 2'b00, 4'b0000, 100000, 1, 0);  // R9 timeout
    run_txn(2'd1, 1, 32'h1000_0001, 32'h0,         2'b01, 2'b01, 4'b1101, 0, 0, 0);   // R9 err cleared

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule